// File: doc/BRIEF.md
# Parallel Port Extended-Capability Controller Core

This block is the host-facing register and data-path core of a bidirectional parallel port. A host reaches it over a small register bus with two windows: the base window holds the data latch, the line status and the control register, while the second window, chosen by a select bit, holds the shared FIFO port and the mode register. The mode register chooses between plain printer output, a bidirectional byte port, a FIFO-fed printer stream, the extended-capability (command/data tagged) stream, an enhanced mode placeholder, a FIFO test mode and configuration access.

In the FIFO-based modes one 16-byte FIFO carries the traffic. On the forward path each entry carries a tag that chooses a command or a data cycle on the port. The forward engine drives an active-low strobe and follows the peripheral's busy line. On the reverse path the core acknowledges each byte offered by the peripheral. It expands run-length-encoded input: a command byte with the top bit clear gives a repeat count for the next data byte. The host services the FIFO by programmed reads and writes, prompted by an interrupt pulse, or by DMA. Handshake timing is counted in core clock cycles.

Top module: `ecp_port_ctrl`

## Requirements
- R1: After reset the mode is compatible (000). A mode register read (select=1, offset 2) returns 0x01: bits 7:5 hold the mode, bit 3 the DMA enable, bit 1 FIFO full and bit 0 FIFO empty. stb_n and irq_n are 1, dma_req and host_ack are 0, and pd_oe is 1.
- R2: In modes 000 and 001 a write to base offset 0 appears on pd_out after the clock edge that takes it. Control register bit 0 set drives stb_n low.
- R3: In mode 000 with control bit 4 set, irq_n follows periph_ack_n one cycle later, as a level that is held for as long as periph_ack_n stays low.
- R4: In a FIFO mode (010, 011, 110) with DMA disabled, a rising service request gives exactly one irq_n low pulse of one cycle.
- R5: The FIFO holds 16 bytes and returns them in order. Writes to a full FIFO are dropped. The full and empty flags are readable in mode register bits 1 and 0.
- R6: The service request is active when at least 8 entries are free (forward, control bit 5 clear) or at least 8 are held (reverse). dma_req equals the service request while mode bit 3 is set. In reverse ECP mode dma_ack pops the head byte and shows it on bus_rdata.
- R7: The forward engine (mode 010, or 011 with control bit 5 clear) pops the head, drives it on pd_out and holds stb_n low until periph_busy is 1. It then releases stb_n and waits for periph_busy to return to 0 before it sends the next entry.
- R8: In mode 011 forward, a base offset 0 write queues a command entry, sent with host_cmd=1. A write to select=1 offset 0 queues a data entry, sent with host_cmd=0.
- R9: In reverse ECP mode (011, control bit 5 set) a received command byte with bit 7 clear sets a count N. The next data byte is pushed N+1 times, for N=0 and for N=127.
- R10: In reverse ECP mode, when periph_ack_n falls the core raises host_ack and holds it until periph_ack_n rises again. A command byte with bit 7 set is discarded. A data byte with no pending count is pushed once.
- R11: Writing mode 000 or 001 while in a FIFO mode empties the FIFO and returns the forward handshake to idle, so stb_n is 1 in the next cycle.
- R12: In mode 001 with control bit 5 set, pd_oe is 0 and a base offset 0 read returns pd_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ext | input | 1 | Selects the second register window |
| bus_addr | input | 2 | Register offset within the window |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a FIFO read pops at the edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| dma_req | output | 1 | DMA service request |
| dma_ack | input | 1 | DMA grant: one FIFO byte per cycle |
| irq_n | output | 1 | Interrupt, active low |
| pd_out | output | 8 | Port data driven out |
| pd_in | input | 8 | Port data received |
| pd_oe | output | 1 | Port data output enable |
| stb_n | output | 1 | Forward strobe, active low |
| host_cmd | output | 1 | Forward cycle is a command cycle |
| host_ack | output | 1 | Reverse acknowledge to the peripheral |
| periph_busy | input | 1 | Peripheral busy / forward handshake reply |
| periph_ack_n | input | 1 | Peripheral acknowledge, reverse byte strobe |
| rev_is_cmd | input | 1 | Reverse byte is a command byte |

## Verification
Register and FIFO-pointer results (pd_out, stb_n from the control register, the FIFO flags and dma_req) are due after the edge that takes the bus write. The bench drives every input on a falling edge and samples on the next falling edge. The interrupt comes one register later. The level check therefore waits one extra cycle, and pulses are counted by a monitor that samples each falling edge. The forward engine needs one edge to see a new entry and one more to pop it. The strobe and data are checked two falling edges after the write, and one falling edge after each change of periph_busy. Reverse results follow a full host_ack handshake, and are checked only after host_ack has dropped.

// File: rtl/ecp_pkg.sv
// Package: shared mode encoding and helpers for the parallel port core.
// Assumes the mode field is three bits wide, as the register layout defines.
package ecp_pkg;
    typedef enum logic [2:0] {
        MODE_COMPAT = 3'b000,
        MODE_BIDIR  = 3'b001,
        MODE_PFIFO  = 3'b010,
        MODE_ECP    = 3'b011,
        MODE_EPP    = 3'b100,
        MODE_RSVD   = 3'b101,
        MODE_TEST   = 3'b110,
        MODE_CFG    = 3'b111
    } port_mode_e;

    // True for modes that move data through the shared FIFO.
    function automatic logic mode_has_fifo(port_mode_e m);
        return (m == MODE_PFIFO) || (m == MODE_ECP) || (m == MODE_TEST);
    endfunction

    // True for modes that the flush-on-exit rule returns to.
    function automatic logic mode_is_plain(port_mode_e m);
        return (m == MODE_COMPAT) || (m == MODE_BIDIR);
    endfunction
endpackage

// File: rtl/ecp_fifo.sv
// Module: synchronous FIFO with an occupancy count and a synchronous flush.
// Assumes DEPTH is a power of two. A push to a full FIFO and a pop from an
// empty FIFO are both ignored. The read data is the head entry (combinational).
module ecp_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic             do_push, do_pop;

    assign full    = (count == DEPTH_C);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr_q];

    // Storage write; the array needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= wdata;
    end

    // Pointer and occupancy update, with flush taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            count  <= '0;
        end else begin
            if (do_push) wptr_q <= wptr_q + 1'b1;
            if (do_pop)  rptr_q <= rptr_q + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/ecp_fwd_engine.sv
// Module: forward handshake engine. It pops one tagged FIFO entry, presents
// it with a low strobe until the peripheral reports busy, then waits for busy
// to clear. Assumes periph_busy is already synchronous to clk.
module ecp_fwd_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         enable,
    input  logic         fifo_empty,
    input  logic [W:0]   fifo_rdata,
    output logic         fifo_pop,
    input  logic         periph_busy,
    output logic         stb_n,
    output logic [W-1:0] dout,
    output logic         cmd
);
    typedef enum logic [1:0] {F_IDLE, F_STB, F_REL} fstate_e;
    fstate_e state_q;

    assign fifo_pop = (state_q == F_IDLE) && enable && !clear && !fifo_empty;
    assign stb_n    = (state_q != F_STB);

    // Handshake sequencing and output latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= F_IDLE;
            dout    <= '0;
            cmd     <= 1'b0;
        end else if (clear || !enable) begin
            state_q <= F_IDLE;
        end else begin
            case (state_q)
                F_IDLE: if (!fifo_empty) begin
                    dout    <= fifo_rdata[W-1:0];
                    cmd     <= fifo_rdata[W];
                    state_q <= F_STB;
                end
                F_STB:   if (periph_busy)  state_q <= F_REL;
                F_REL:   if (!periph_busy) state_q <= F_IDLE;
                default: state_q <= F_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ecp_rev_engine.sv
// Module: reverse receive engine with run-length expansion. A command byte
// with the top bit clear arms a repeat count N; the next data byte is pushed
// N+1 times, one per cycle, stalling while the FIFO is full. host_ack stays
// high from byte capture until the peripheral releases its strobe.
module ecp_rev_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         enable,
    input  logic         periph_stb_n,
    input  logic         rev_cmd,
    input  logic [W-1:0] din,
    input  logic         fifo_full,
    output logic         push,
    output logic [W-1:0] push_data,
    output logic         host_ack
);
    typedef enum logic [1:0] {R_IDLE, R_EXPAND, R_WAITREL} rstate_e;
    rstate_e        state_q;
    logic [W-2:0]   run_q, rep_q;
    logic [W-1:0]   byte_q;
    logic           armed_q;
    logic           take_plain;

    assign take_plain = (state_q == R_IDLE) && !periph_stb_n && !rev_cmd
                        && !armed_q && !fifo_full;
    assign push       = enable && !clear
                        && (take_plain || ((state_q == R_EXPAND) && !fifo_full));
    assign push_data  = (state_q == R_EXPAND) ? byte_q : din;
    assign host_ack   = (state_q != R_IDLE);

    // Byte capture, count arming and repeat expansion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= R_IDLE;
            run_q   <= '0;
            rep_q   <= '0;
            byte_q  <= '0;
            armed_q <= 1'b0;
        end else if (clear || !enable) begin
            state_q <= R_IDLE;
            armed_q <= 1'b0;
        end else begin
            case (state_q)
                R_IDLE: if (!periph_stb_n) begin
                    if (rev_cmd) begin
                        if (!din[W-1]) begin
                            run_q   <= din[W-2:0];
                            armed_q <= 1'b1;
                        end
                        state_q <= R_WAITREL;
                    end else if (armed_q) begin
                        rep_q   <= run_q;
                        byte_q  <= din;
                        armed_q <= 1'b0;
                        state_q <= R_EXPAND;
                    end else if (!fifo_full) begin
                        state_q <= R_WAITREL;
                    end
                end
                R_EXPAND: if (!fifo_full) begin
                    if (rep_q == '0) state_q <= R_WAITREL;
                    else             rep_q   <= rep_q - 1'b1;
                end
                R_WAITREL: if (periph_stb_n) state_q <= R_IDLE;
                default:   state_q <= R_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ecp_port_ctrl.sv
// Module: top of the parallel port core. It decodes the two register windows,
// holds the data, control and mode registers, routes the shared FIFO between
// the host, DMA and the two handshake engines, and forms the service request
// and the interrupt. Assumes a byte-wide bus and that all port inputs are
// already synchronous to clk.
module ecp_port_ctrl
    import ecp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int SVC_THRESH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ext,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dma_req,
    input  logic              dma_ack,
    output logic              irq_n,
    output logic [DATA_W-1:0] pd_out,
    input  logic [DATA_W-1:0] pd_in,
    output logic              pd_oe,
    output logic              stb_n,
    output logic              host_cmd,
    output logic              host_ack,
    input  logic              periph_busy,
    input  logic              periph_ack_n,
    input  logic              rev_is_cmd
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C  = CW'(FIFO_DEPTH);
    localparam logic [CW-1:0] THRESH_C = CW'(SVC_THRESH);

    port_mode_e        mode_q;
    logic              dma_en_q, svc_q;
    logic [DATA_W-1:0] ctrl_q, data_q;
    logic              wr_base0, wr_ctrl, wr_fifo, wr_ecr, rd_fifo;
    logic              fifo_mode, dir_rev, fwd_en, rev_en, flush, svc;
    logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [DATA_W:0]   fifo_wdata, fifo_rd;
    logic [CW-1:0]     fifo_count;
    logic              fwd_pop, fwd_stb_n, fwd_cmd, rev_push;
    logic [DATA_W-1:0] fwd_dout, rev_data;
    port_mode_e        new_mode;

    assign wr_base0  = bus_wr && !bus_ext && (bus_addr == 2'd0);
    assign wr_ctrl   = bus_wr && !bus_ext && (bus_addr == 2'd2);
    assign wr_fifo   = bus_wr &&  bus_ext && (bus_addr == 2'd0);
    assign wr_ecr    = bus_wr &&  bus_ext && (bus_addr == 2'd2);
    assign rd_fifo   = bus_rd &&  bus_ext && (bus_addr == 2'd0);
    assign new_mode  = port_mode_e'(bus_wdata[DATA_W-1 -: 3]);
    assign fifo_mode = mode_has_fifo(mode_q);
    assign dir_rev   = ctrl_q[5];
    assign fwd_en    = (mode_q == MODE_PFIFO) || ((mode_q == MODE_ECP) && !dir_rev);
    assign rev_en    = (mode_q == MODE_ECP) && dir_rev;
    assign flush     = wr_ecr && fifo_mode && mode_is_plain(new_mode);

    // FIFO source and sink selection among host, DMA and the engines.
    always_comb begin
        if (rev_en) begin
            fifo_push  = rev_push;
            fifo_wdata = {1'b0, rev_data};
        end else begin
            fifo_push  = (wr_fifo && ((mode_q == MODE_TEST) || fwd_en))
                       || (wr_base0 && fwd_en && (mode_q == MODE_ECP))
                       || (dma_ack && dma_en_q && fwd_en);
            fifo_wdata = {wr_base0 && (mode_q == MODE_ECP), bus_wdata};
        end
        fifo_pop = fwd_pop
                 || (rd_fifo && ((mode_q == MODE_TEST) || rev_en))
                 || (dma_ack && dma_en_q && rev_en);
    end

    // Service request: free space going forward, held data going in reverse.
    assign svc     = fifo_mode && (dir_rev ? (fifo_count >= THRESH_C)
                                           : ((DEPTH_C - fifo_count) >= THRESH_C));
    assign dma_req = svc && dma_en_q;

    // Register file: data latch, control and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_COMPAT;
            dma_en_q <= 1'b0;
            ctrl_q   <= '0;
            data_q   <= '0;
        end else begin
            if (wr_base0 && !fifo_mode) data_q <= bus_wdata;
            if (wr_ctrl) ctrl_q <= bus_wdata;
            if (wr_ecr) begin
                mode_q   <= new_mode;
                dma_en_q <= bus_wdata[3];
            end
        end
    end

    // Interrupt: a level in compatible mode, one-cycle pulses in FIFO modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
            svc_q <= 1'b0;
        end else begin
            svc_q <= svc;
            if (mode_q == MODE_COMPAT) irq_n <= !(ctrl_q[4] && !periph_ack_n);
            else if (fifo_mode)        irq_n <= !(svc && !svc_q && !dma_en_q);
            else                       irq_n <= 1'b1;
        end
    end

    // Read data multiplexer, with the DMA read path taking priority.
    always_comb begin
        bus_rdata = '0;
        if (dma_ack && dma_en_q && rev_en) begin
            bus_rdata = fifo_rd[DATA_W-1:0];
        end else if (bus_rd) begin
            case ({bus_ext, bus_addr})
                3'b000:  bus_rdata = (dir_rev && (mode_q == MODE_BIDIR)) ? pd_in : data_q;
                3'b001:  bus_rdata = {periph_busy, periph_ack_n, {(DATA_W-2){1'b0}}};
                3'b010:  bus_rdata = ctrl_q;
                3'b100:  bus_rdata = ((mode_q == MODE_TEST) || rev_en) ? fifo_rd[DATA_W-1:0] : '0;
                3'b110:  bus_rdata = {mode_q, 1'b0, dma_en_q, 1'b0, fifo_full, fifo_empty};
                default: bus_rdata = '0;
            endcase
        end
    end

    assign pd_out   = fifo_mode ? fwd_dout : data_q;
    assign pd_oe    = !(((mode_q == MODE_BIDIR) || (mode_q == MODE_ECP)) && dir_rev);
    assign stb_n    = fifo_mode ? fwd_stb_n : !ctrl_q[0];
    assign host_cmd = fifo_mode && fwd_cmd;

    ecp_fifo #(.WIDTH(DATA_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(fifo_push), .wdata(fifo_wdata), .pop(fifo_pop), .rdata(fifo_rd),
        .full(fifo_full), .empty(fifo_empty), .count(fifo_count)
    );

    ecp_fwd_engine #(.W(DATA_W)) u_fwd (
        .clk(clk), .rst_n(rst_n), .clear(flush), .enable(fwd_en),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rd), .fifo_pop(fwd_pop),
        .periph_busy(periph_busy), .stb_n(fwd_stb_n), .dout(fwd_dout), .cmd(fwd_cmd)
    );

    ecp_rev_engine #(.W(DATA_W)) u_rev (
        .clk(clk), .rst_n(rst_n), .clear(flush), .enable(rev_en),
        .periph_stb_n(periph_ack_n), .rev_cmd(rev_is_cmd), .din(pd_in),
        .fifo_full(fifo_full), .push(rev_push), .push_data(rev_data), .host_ack(host_ack)
    );
endmodule

// File: rtl/ecp_port_ctrl_sva.sv
// Module: assertion checker for ecp_port_ctrl, attached by the bind below.
// It observes top-level ports and the signals passed between the sub-blocks.
module ecp_port_ctrl_sva (
    input logic clk,
    input logic rst_n,
    input logic fifo_mode,
    input logic wr_ecr,
    input logic irq_n,
    input logic dma_req,
    input logic fwd_en,
    input logic rev_en,
    input logic fwd_stb_n,
    input logic pd_oe,
    input logic host_ack,
    input logic periph_ack_n,
    input logic flush,
    input logic fifo_full,
    input logic fifo_empty
);
    // R5: the FIFO can never report full and empty together.
    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R4: a FIFO-mode interrupt pulse lasts exactly one cycle.
    assert_irq_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && fifo_mode && $past(fifo_mode) && !wr_ecr) |=> irq_n);

    // R6: a reverse request implies data is held; a forward request implies room.
    assert_rev_request_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && rev_en) |-> !fifo_empty);
    assert_fwd_request_has_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && fwd_en) |-> !fifo_full);

    // R7: the forward strobe is only driven while the port drives data.
    assert_strobe_with_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwd_stb_n && fwd_en) |-> pd_oe);

    // R10: host_ack rises only after the peripheral strobe was seen low.
    assert_ack_follows_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ack) |-> $past(!periph_ack_n));

    // R11: a flush empties the FIFO and idles the forward handshake.
    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fifo_empty && fwd_stb_n));
endmodule

bind ecp_port_ctrl ecp_port_ctrl_sva u_sva (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .wr_ecr(wr_ecr),
    .irq_n(irq_n), .dma_req(dma_req), .fwd_en(fwd_en), .rev_en(rev_en),
    .fwd_stb_n(fwd_stb_n), .pd_oe(pd_oe), .host_ack(host_ack),
    .periph_ack_n(periph_ack_n), .flush(flush),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
);

// File: tb/test_ecp_port_ctrl.sv
// Directed bench for ecp_port_ctrl: one task per scenario, each checking its
// own results. Inputs change on falling edges and outputs are sampled there.
module test_ecp_port_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_ext = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00, pd_in = 8'h00;
    logic       dma_ack = 1'b0, periph_busy = 1'b0, periph_ack_n = 1'b1, rev_is_cmd = 1'b0;
    logic [7:0] bus_rdata, pd_out;
    logic       dma_req, irq_n, pd_oe, stb_n, host_cmd, host_ack;

    int checks = 0;
    int fails  = 0;
    int irq_lows = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ecp_port_ctrl i_ecp_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_ext(bus_ext), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_req(dma_req), .dma_ack(dma_ack), .irq_n(irq_n), .pd_out(pd_out),
        .pd_in(pd_in), .pd_oe(pd_oe), .stb_n(stb_n), .host_cmd(host_cmd),
        .host_ack(host_ack), .periph_busy(periph_busy), .periph_ack_n(periph_ack_n),
        .rev_is_cmd(rev_is_cmd)
    );

    // Count cycles with the interrupt line low, to measure pulses.
    always @(negedge clk) if (rst_n && !irq_n) irq_lows++;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic ext, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_ext = ext; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic ext, input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_ext = ext; bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_rev(input logic [7:0] b, input logic is_cmd);
        @(negedge clk);
        pd_in = b; rev_is_cmd = is_cmd; periph_ack_n = 1'b0;
        do @(negedge clk); while (!host_ack);
        periph_ack_n = 1'b1;
        do @(negedge clk); while (host_ack);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        bus_read(1'b1, 2'd2, r);
        chk("R1 mode reg", r, 8'h01);
        chk("R1 stb_n", stb_n, 1'b1);
        chk("R1 irq_n", irq_n, 1'b1);
        chk("R1 dma_req", dma_req, 1'b0);
        chk("R1 pd_oe", pd_oe, 1'b1);
        chk("R1 host_ack", host_ack, 1'b0);
    endtask

    task automatic t_compat();
        bus_write(1'b0, 2'd0, 8'h5A);
        chk("R2 pd_out", pd_out, 8'h5A);
        bus_write(1'b0, 2'd2, 8'h01);
        chk("R2 stb_n low", stb_n, 1'b0);
        bus_write(1'b0, 2'd2, 8'h10);
        chk("R2 stb_n high", stb_n, 1'b1);
        periph_ack_n = 1'b0;
        @(negedge clk); chk("R3 irq level", irq_n, 1'b0);
        @(negedge clk); chk("R3 irq held", irq_n, 1'b0);
        periph_ack_n = 1'b1;
        @(negedge clk); chk("R3 irq release", irq_n, 1'b1);
        bus_write(1'b0, 2'd2, 8'h00);
    endtask

    task automatic t_bidir();
        logic [7:0] r;
        bus_write(1'b0, 2'd2, 8'h20);
        bus_write(1'b1, 2'd2, 8'h20);
        chk("R12 pd_oe off", pd_oe, 1'b0);
        pd_in = 8'hC3;
        bus_read(1'b0, 2'd0, r);
        chk("R12 read pd_in", r, 8'hC3);
        bus_write(1'b1, 2'd2, 8'h00);
        bus_write(1'b0, 2'd2, 8'h00);
        chk("R12 pd_oe back", pd_oe, 1'b1);
    endtask

    task automatic t_test_fifo();
        logic [7:0] r;
        int base;
        bus_write(1'b1, 2'd2, 8'hC8);
        chk("R6 empty requests", dma_req, 1'b1);
        for (int i = 0; i < 8; i++) bus_write(1'b1, 2'd0, 8'h10 + 8'(i));
        chk("R6 8 free", dma_req, 1'b1);
        bus_write(1'b1, 2'd0, 8'h18);
        chk("R6 7 free", dma_req, 1'b0);
        for (int i = 9; i < 16; i++) bus_write(1'b1, 2'd0, 8'h10 + 8'(i));
        bus_read(1'b1, 2'd2, r);
        chk("R5 full flag", r, 8'hCA);
        bus_write(1'b1, 2'd0, 8'hEE);
        for (int i = 0; i < 16; i++) begin
            bus_read(1'b1, 2'd0, r);
            chk("R5 order", r, 8'h10 + 8'(i));
        end
        bus_read(1'b1, 2'd2, r);
        chk("R5 empty after 16, overflow dropped", r, 8'hC9);
        bus_write(1'b1, 2'd2, 8'hC0);
        repeat (2) @(negedge clk);
        base = irq_lows;
        for (int i = 0; i < 9; i++) bus_write(1'b1, 2'd0, 8'(i));
        bus_read(1'b1, 2'd0, r);
        repeat (3) @(negedge clk);
        chk("R4 one pulse", 16'(irq_lows - base), 16'd1);
        bus_write(1'b1, 2'd2, 8'h00);
        bus_read(1'b1, 2'd2, r);
        chk("R11 flushed from test", r, 8'h01);
    endtask

    task automatic periph_take(input logic [7:0] d, input logic c);
        chk("R7 strobe low", stb_n, 1'b0);
        chk("R7 data", pd_out, d);
        chk("R8 tag", host_cmd, c);
        repeat (2) @(negedge clk);
        chk("R7 strobe held", stb_n, 1'b0);
        periph_busy = 1'b1;
        @(negedge clk);
        chk("R7 strobe release", stb_n, 1'b1);
        @(negedge clk);
        chk("R7 wait busy", stb_n, 1'b1);
        periph_busy = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_forward();
        logic [7:0] r;
        bus_write(1'b1, 2'd2, 8'h60);
        bus_write(1'b0, 2'd0, 8'h81);
        bus_write(1'b1, 2'd0, 8'h42);
        periph_take(8'h81, 1'b1);
        periph_take(8'h42, 1'b0);
        chk("R7 idle after last", stb_n, 1'b1);
        bus_read(1'b1, 2'd2, r);
        chk("R7 drained", r, 8'h61);
        bus_write(1'b1, 2'd2, 8'h00);
    endtask

    task automatic t_flush();
        logic [7:0] r;
        bus_write(1'b1, 2'd2, 8'h40);
        for (int i = 0; i < 3; i++) bus_write(1'b1, 2'd0, 8'hA0 + 8'(i));
        chk("R11 stuck in strobe", stb_n, 1'b0);
        bus_write(1'b1, 2'd2, 8'h00);
        chk("R11 strobe idle", stb_n, 1'b1);
        bus_read(1'b1, 2'd2, r);
        chk("R11 empty", r, 8'h01);
        bus_write(1'b1, 2'd2, 8'h40);
        repeat (3) @(negedge clk);
        chk("R11 nothing left to send", stb_n, 1'b1);
        bus_write(1'b1, 2'd2, 8'h00);
    endtask

    task automatic t_reverse();
        logic [7:0] r;
        int got, bad, guard;
        bus_write(1'b0, 2'd2, 8'h20);
        bus_write(1'b1, 2'd2, 8'h60);
        send_rev(8'h00, 1'b1);
        send_rev(8'h5C, 1'b0);
        bus_read(1'b1, 2'd0, r);
        chk("R9 count 0 byte", r, 8'h5C);
        bus_read(1'b1, 2'd2, r);
        chk("R9 count 0 single", r, 8'h61);
        send_rev(8'h33, 1'b0);
        send_rev(8'h85, 1'b1);
        send_rev(8'h44, 1'b0);
        bus_read(1'b1, 2'd0, r);
        chk("R10 plain byte", r, 8'h33);
        bus_read(1'b1, 2'd0, r);
        chk("R10 channel cmd dropped", r, 8'h44);
        bus_read(1'b1, 2'd2, r);
        chk("R10 nothing more", r, 8'h61);
        got = 0; bad = 0; guard = 0;
        fork
            begin
                send_rev(8'h7F, 1'b1);
                send_rev(8'hA7, 1'b0);
            end
        join_none
        while (got < 128 && guard < 4000) begin
            guard++;
            bus_read(1'b1, 2'd2, r);
            if (!r[0]) begin
                bus_read(1'b1, 2'd0, r);
                got++;
                if (r != 8'hA7) bad++;
            end
        end
        wait fork;
        chk("R9 count 127 length", 16'(got), 16'd128);
        chk("R9 count 127 value", 16'(bad), 16'd0);
        bus_read(1'b1, 2'd2, r);
        chk("R9 count 127 no extra", r, 8'h61);
    endtask

    task automatic t_rev_dma();
        logic [7:0] r;
        bus_write(1'b1, 2'd2, 8'h68);
        send_rev(8'h06, 1'b1);
        send_rev(8'h11, 1'b0);
        chk("R6 7 held", dma_req, 1'b0);
        send_rev(8'h12, 1'b0);
        chk("R6 8 held", dma_req, 1'b1);
        @(negedge clk);
        dma_ack = 1'b1;
        #1 r = bus_rdata;
        chk("R6 dma head", r, 8'h11);
        @(negedge clk);
        dma_ack = 1'b0;
        chk("R6 dma popped", dma_req, 1'b0);
        bus_write(1'b1, 2'd2, 8'h00);
        bus_read(1'b1, 2'd2, r);
        chk("R11 flushed from reverse", r, 8'h01);
        bus_write(1'b0, 2'd2, 8'h00);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_compat();
        t_bidir();
        t_test_fifo();
        t_forward();
        t_flush();
        t_reverse();
        t_rev_dma();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule